// File: doc/BRIEF.md
# Dual-Half SECDED Protected Buffer

This block is a synchronous single-port memory that keeps 128-bit data words under error-correcting protection. On a write it splits the word into a lower and an upper 64-bit half. For each half it derives an 8-bit check field: seven Hamming bits and one overall parity bit. The full 144-bit entry then goes into an inferred array. The number of entries is a parameter. A small depth suits a descriptor store and a large depth suits a packet store.

On a read the stored entry is registered, and each half is decoded on its own. A single flipped bit in a half is repaired on the output path and reported as correctable. This holds whether the bit is a data bit or one of that half's check bits. A double flip in a half is reported as uncorrectable. The two per-half uncorrectable indications are merged into one pulse for the error-handling logic. Read data, the per-half flags and a valid strobe all appear one clock after the read request.

A test port XORs a chosen 144-bit mask onto the entry as it is written. A bench uses it to place single and double errors at known positions.

Top module: `secded_dual_buffer`

## Requirements
- R1: While reset is held and after it is released, `rd_valid_o`, `cor_err_o`, `unc_err_o` and `unc_pulse_o` are all low until a read is issued.
- R2: A word written with no injection reads back unchanged at the same address, with both per-half flags clear.
- R3: `rd_valid_o` is high in exactly the cycle after a clock edge that samples `req_i`=1 and `we_i`=0. It is low after a write cycle and after an idle cycle.
- R4: A single flipped data bit in the lower half (stored bits 63:0) is corrected on `rd_data_o`, and only `cor_err_o[0]` is set.
- R5: A single flipped data bit in the upper half (stored bits 127:64) is corrected on `rd_data_o`, and only `cor_err_o[1]` is set.
- R6: A single flipped check bit leaves `rd_data_o` equal to the written data and sets the correctable flag of its half. The lower half's check field is stored bits 135:128 and the upper half's is 143:136.
- R7: Two flipped bits within one half set that half's `unc_err_o` bit and not its `cor_err_o` bit. This holds for two data bits and for a data bit paired with a check bit.
- R8: Single errors in both halves of one entry are corrected together; `cor_err_o` is 2'b11 and `unc_pulse_o` stays low.
- R9: `unc_pulse_o` equals the OR of the two `unc_err_o` bits and is high only in a cycle where `rd_valid_o` is high.
- R10: The injection mask alters the stored entry only when `inj_en_i` is high during the write. With `inj_en_i` low, any mask leaves the read-back clean.
- R11: Entries at address 0 and at address DEPTH-1 hold independent contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read (when `req_i` is high) |
| addr_i | input | ADDR_W | Entry address |
| wr_data_i | input | 128 | Write data |
| inj_en_i | input | 1 | Apply the injection mask to this write |
| inj_mask_i | input | 144 | Bits of the stored entry to invert |
| rd_data_o | output | 128 | Corrected read data |
| rd_valid_o | output | 1 | Read data and flags valid |
| cor_err_o | output | 2 | Per-half correctable error (bit 0 lower, bit 1 upper) |
| unc_err_o | output | 2 | Per-half uncorrectable error |
| unc_pulse_o | output | 1 | Merged uncorrectable event |

## Verification
Correction in one half and detection in the other can fall on the same read. So can corrections in both halves at once. The bench provokes this by writing one entry with a single flip in the lower half and a double flip in the upper half, and another entry with a single flip in each half. It then judges that the repaired half's data is exact, that each half raises only its own flag, and that the merged pulse follows the uncorrectable half alone.

// File: rtl/dhb_pkg.sv
package dhb_pkg;

  localparam int unsigned DATA_W = 128;
  localparam int unsigned HALF_W = 64;
  localparam int unsigned HAM_W  = 7;
  localparam int unsigned CHK_W  = HAM_W + 1;
  localparam int unsigned HALVES = DATA_W / HALF_W;
  localparam int unsigned WORD_W = DATA_W + HALVES * CHK_W;
  localparam int unsigned CW_LEN = HALF_W + HAM_W;

  // Hamming bits: data bits are placed at the codeword positions that are
  // not powers of two; bit k covers every position with bit k set.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [HALF_W-1:0] d);
    logic [HAM_W-1:0] h;
    int unsigned      di;
    h  = '0;
    di = 0;
    for (int unsigned p = 1; p <= CW_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int unsigned k = 0; k < HAM_W; k++) begin
          if (p[k]) h[k] = h[k] ^ d[di];
        end
        di++;
      end
    end
    return h;
  endfunction

  // Invert the data bit that sits at codeword position syn (if any).
  function automatic logic [HALF_W-1:0] flip_pos(input logic [HALF_W-1:0] d,
                                                 input logic [HAM_W-1:0]  syn);
    logic [HALF_W-1:0] r;
    int unsigned       di;
    r  = d;
    di = 0;
    for (int unsigned p = 1; p <= CW_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (int'(syn) == int'(p)) r[di] = ~d[di];
        di++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/dhb_rst_sync.sv
module dhb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dhb_half_enc.sv
module dhb_half_enc
  import dhb_pkg::*;
(
  input  logic [HALF_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [HAM_W-1:0] ham;

  always_comb begin
    ham   = ham_bits(data_i);
    chk_o = {^{ham, data_i}, ham};
  end
endmodule

// File: rtl/dhb_half_dec.sv
module dhb_half_dec
  import dhb_pkg::*;
(
  input  logic [HALF_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [HALF_W-1:0] data_o,
  output logic              sbe_o,
  output logic              dbe_o
);
  logic [HAM_W-1:0] syn;
  logic             par_odd;
  logic             syn_nz;
  logic             syn_in_range;

  always_comb begin
    syn          = ham_bits(data_i) ^ chk_i[HAM_W-1:0];
    par_odd      = ^{chk_i, data_i};
    syn_nz       = |syn;
    syn_in_range = int'(syn) <= int'(CW_LEN);
    // odd parity: one flip (or odd multi-flip if the syndrome points nowhere)
    sbe_o        = par_odd && syn_in_range;
    dbe_o        = (!par_odd && syn_nz) || (par_odd && !syn_in_range);
    data_o       = sbe_o ? flip_pos(data_i, syn) : data_i;
  end
endmodule

// File: rtl/dhb_store.sv
module dhb_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WIDTH  = 144,
  parameter int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wr_word_i,
  output logic [WIDTH-1:0]  rd_word_o,
  output logic              rd_valid_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rd_word_d;
  logic             rd_valid_d;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wr_word_i;
  end

  always_comb begin
    rd_valid_d = rd_en_i;
    rd_word_d  = rd_en_i ? mem_q[addr_i] : rd_word_o;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_valid_o <= 1'b0;
      rd_word_o  <= '0;
    end else begin
      rd_valid_o <= rd_valid_d;
      rd_word_o  <= rd_word_d;
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i || rd_en_i) |-> (int'(addr_i) < int'(DEPTH))); // R11
endmodule

// File: rtl/secded_dual_buffer.sv
module secded_dual_buffer
  import dhb_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inj_en_i,
  input  logic [WORD_W-1:0] inj_mask_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [HALVES-1:0] cor_err_o,
  output logic [HALVES-1:0] unc_err_o,
  output logic              unc_pulse_o
);
  logic                          rst_n;
  logic                          wr_en;
  logic                          rd_en;
  logic [HALVES-1:0][CHK_W-1:0]  wr_chk;
  logic [WORD_W-1:0]             wr_word;
  logic [WORD_W-1:0]             rd_word;
  logic                          rd_valid;
  logic [HALVES-1:0][HALF_W-1:0] dec_data;
  logic [HALVES-1:0]             dec_sbe;
  logic [HALVES-1:0]             dec_dbe;

  dhb_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  always_comb begin
    wr_en   = req_i && we_i;
    rd_en   = req_i && !we_i;
    wr_word = {wr_chk, wr_data_i} ^ (inj_en_i ? inj_mask_i : '0);
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    dhb_half_enc enc_i (
      .data_i (wr_data_i[h*HALF_W +: HALF_W]),
      .chk_o  (wr_chk[h])
    );
    dhb_half_dec dec_i (
      .data_i (rd_word[h*HALF_W +: HALF_W]),
      .chk_i  (rd_word[DATA_W + h*CHK_W +: CHK_W]),
      .data_o (dec_data[h]),
      .sbe_o  (dec_sbe[h]),
      .dbe_o  (dec_dbe[h])
    );
  end

  dhb_store #(.DEPTH(DEPTH), .WIDTH(WORD_W), .ADDR_W(ADDR_W)) store_i (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr_i),
    .wr_word_i  (wr_word),
    .rd_word_o  (rd_word),
    .rd_valid_o (rd_valid)
  );

  always_comb begin
    rd_data_o   = dec_data;
    rd_valid_o  = rd_valid;
    cor_err_o   = rd_valid ? dec_sbe : '0;
    unc_err_o   = rd_valid ? dec_dbe : '0;
    unc_pulse_o = rd_valid && (|dec_dbe);
  end

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_en |=> rd_valid_o); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_valid_o |-> $past(req_i && !we_i)); // R3
  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    unc_pulse_o |-> rd_valid_o); // R9
  AST_PULSE_FROM_HALF: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_valid_o |-> (unc_pulse_o == (|dec_dbe))); // R9
  AST_HALF_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cor_err_o & unc_err_o) == '0); // R7
  AST_CLEAN_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_valid_o && cor_err_o == '0 && unc_err_o == '0) |->
    (rd_data_o == rd_word[DATA_W-1:0])); // R2
endmodule

// File: tb/secded_dual_buffer_tb.sv
`timescale 1ns/1ps
module secded_dual_buffer_tb_top;
  localparam int unsigned DEPTH  = 64;
  localparam int unsigned ADDR_W = 6;

  logic         clk;
  logic         rst_n;
  logic         req;
  logic         we;
  logic [ADDR_W-1:0] addr;
  logic [127:0] wdata;
  logic         inj_en;
  logic [143:0] inj_mask;
  logic [127:0] rdata;
  logic         rvalid;
  logic [1:0]   cor;
  logic [1:0]   unc;
  logic         upulse;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  secded_dual_buffer #(.DEPTH(DEPTH)) dut_i (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .req_i       (req),
    .we_i        (we),
    .addr_i      (addr),
    .wr_data_i   (wdata),
    .inj_en_i    (inj_en),
    .inj_mask_i  (inj_mask),
    .rd_data_o   (rdata),
    .rd_valid_o  (rvalid),
    .cor_err_o   (cor),
    .unc_err_o   (unc),
    .unc_pulse_o (upulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req_tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [127:0] d,
                    input logic ie, input logic [143:0] m);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; inj_en = ie; inj_mask = m;
    @(negedge clk);
    req = 0; we = 0; inj_en = 0; inj_mask = '0;
  endtask

  // read and check flags; data checked only when chk_data set
  task automatic rd(input string tag, input logic [ADDR_W-1:0] a,
                    input logic chk_data, input logic [127:0] exp_d,
                    input logic [1:0] exp_cor, input logic [1:0] exp_unc);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    chk(tag, "rd_valid", {127'b0, rvalid}, 128'd1);
    if (chk_data) chk(tag, "rd_data", rdata, exp_d);
    chk(tag, "cor_err", {126'b0, cor}, {126'b0, exp_cor});
    chk(tag, "unc_err", {126'b0, unc}, {126'b0, exp_unc});
    chk("R9", "unc_pulse", {127'b0, upulse}, {127'b0, |exp_unc});
    @(negedge clk);
    chk("R3", "valid drops after idle", {127'b0, rvalid}, 128'd0);
    chk("R9", "pulse low without valid", {127'b0, upulse}, 128'd0);
  endtask

  function automatic logic [143:0] bit1(input int p);
    return 144'd1 << p;
  endfunction

  localparam logic [127:0] P0 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] P1 = 128'hDEAD_BEEF_0000_FFFF_A5A5_5A5A_1357_9BDF;

  task automatic t_reset;
    chk("R1", "valid in reset", {127'b0, rvalid}, 128'd0);
    chk("R1", "flags in reset", {123'b0, cor, unc, upulse}, 128'd0);
  endtask

  task automatic t_clean;
    wr(6'd1, P0, 1'b0, '0);
    @(negedge clk);
    chk("R3", "no valid after write", {127'b0, rvalid}, 128'd0);
    rd("R2", 6'd1, 1'b1, P0, 2'b00, 2'b00);
  endtask

  task automatic t_singles;
    wr(6'd2, P1, 1'b1, bit1(17));
    rd("R4", 6'd2, 1'b1, P1, 2'b01, 2'b00);
    wr(6'd3, P1, 1'b1, bit1(100));
    rd("R5", 6'd3, 1'b1, P1, 2'b10, 2'b00);
    wr(6'd4, P0, 1'b1, bit1(130));
    rd("R6", 6'd4, 1'b1, P0, 2'b01, 2'b00);
    wr(6'd5, P0, 1'b1, bit1(143));
    rd("R6", 6'd5, 1'b1, P0, 2'b10, 2'b00);
  endtask

  task automatic t_doubles;
    wr(6'd6, P0, 1'b1, bit1(3) | bit1(40));
    rd("R7", 6'd6, 1'b0, '0, 2'b00, 2'b01);
    wr(6'd7, P1, 1'b1, bit1(70) | bit1(137));
    rd("R7", 6'd7, 1'b0, '0, 2'b00, 2'b10);
  endtask

  task automatic t_same_cycle;
    wr(6'd8, P1, 1'b1, bit1(9) | bit1(88));
    rd("R8", 6'd8, 1'b1, P1, 2'b11, 2'b00);
    wr(6'd9, P0, 1'b1, bit1(22) | bit1(65) | bit1(127));
    @(negedge clk);
    req = 1; we = 0; addr = 6'd9;
    @(negedge clk);
    req = 0;
    chk("R8", "lower data repaired", {64'b0, rdata[63:0]}, {64'b0, P0[63:0]});
    chk("R8", "cor lower only", {126'b0, cor}, 128'd1);
    chk("R9", "unc upper only", {126'b0, unc}, 128'd2);
    chk("R9", "merged pulse", {127'b0, upulse}, 128'd1);
  endtask

  task automatic t_inj_gate;
    wr(6'd10, P1, 1'b0, bit1(5) | bit1(77) | bit1(140));
    rd("R10", 6'd10, 1'b1, P1, 2'b00, 2'b00);
  endtask

  task automatic t_depth;
    wr(6'd0, P0, 1'b0, '0);
    wr(6'(DEPTH-1), P1, 1'b0, '0);
    rd("R11", 6'd0, 1'b1, P0, 2'b00, 2'b00);
    rd("R11", 6'(DEPTH-1), 1'b1, P1, 2'b00, 2'b00);
  endtask

  initial begin
    rst_n = 0; req = 0; we = 0; addr = '0; wdata = '0; inj_en = 0; inj_mask = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_clean;
    t_singles;
    t_doubles;
    t_same_cycle;
    t_inj_gate;
    t_depth;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule